// File: doc/BRIEF.md
# Bus-commanded converter enable receiver

This block is the slave side of a two-wire management bus. It understands one transaction only: a write of a single command byte. Its output is three enable lines for a set of power converters: the 3.3 V buck, the 5 V buck and the flyback. The block runs on a system clock much faster than the bus. Both bus lines pass through a two-flop synchronizer and then a glitch filter. Start and stop conditions, and the clock edges, are taken from the filtered lines.

The slave acknowledges its own write address and then the command byte. It does this by asserting a pull-low enable, which stands in for an open-drain pad. The three upper command bits are held in a shadow register. They reach the enable outputs only when a stop ends a complete transaction. A stop that comes early discards everything. A wrong address, a read request, or a byte beyond the command leaves the enables alone. A start at any point restarts address reception.

Top module: `smbus_enable_rx`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. Both are judged on the filtered lines. Data bits are taken on the rising edges of SCL, most significant bit first.
- R2: When the first byte after a start is 0x60 (7-bit address 0x30 with bit 0, the write bit, at 0), `sda_pull_o` is asserted from the SCL falling edge after the eighth bit until the next SCL falling edge.
- R3: An address byte other than 0x60, including 0x61 (read bit set), gets no acknowledge. It leaves the enables unchanged, and the block ignores the bus until the next start.
- R4: After an acknowledged address, the command byte is acknowledged in the same way as the address: pull asserted from the falling edge after its eighth bit until the following falling edge.
- R5: A stop after the command acknowledge loads the enables from the command byte. Bit 7 drives `en_buck3_o`, bit 6 drives `en_buck5_o` and bit 5 drives `en_fly_o`. Bits 4 to 0 have no effect, and 0x00 clears all three.
- R6: A stop at any earlier point of the sequence leaves the enables unchanged, and the block waits for the next start.
- R7: A start in the middle of a transfer drops any partial command and restarts address reception.
- R8: A command that matches the present enable state causes no change on any enable line.
- R9: A pulse on SCL or SDA shorter than `FILT` system clocks is ignored.
- R10: During and right after reset, the enables equal `RESET_EN` (default 000) and `sda_pull_o` is low.
- R11: A further clocked bit after the command acknowledge, such as a second data byte, makes the transaction invalid. It gets no acknowledge, and the stop that follows leaves the enables unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired-AND level) |
| sda_pull_o | output | 1 | Pull-low enable for the open-drain data driver |
| en_buck3_o | output | 1 | Enable for the 3.3 V buck converter |
| en_buck5_o | output | 1 | Enable for the 5 V buck converter |
| en_fly_o | output | 1 | Enable for the flyback converter |

## Verification
The bench sends complete writes with several command bytes. These include a byte with the low bits set, which shows that only bits 7 to 5 count, and a repeat of the current state, which shows that nothing toggles. It sends mistaken addresses (a different address and a read request) to tell acknowledgement apart from silent ignoring. It sends stops at several early points, a repeated start inside the command byte, and a second data byte. Each of these separates a commit from a discard, because the enables are watched on every clock outside a short settling window. A one-cycle SCL pulse inside the address byte shows that the filter works: without the filter, the extra bit would misalign the byte and lose the acknowledge.

// File: rtl/smbus_enable_rx.sv
module smbus_enable_rx #(
  parameter int         FILT     = 3,
  parameter logic [6:0] DEV_ADDR = 7'h30,
  parameter logic [2:0] RESET_EN = 3'b000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_pull_o,
  output logic en_buck3_o,
  output logic en_buck5_o,
  output logic en_fly_o
);

  localparam logic [2:0] S_IDLE = 3'd0;
  localparam logic [2:0] S_ADDR = 3'd1;
  localparam logic [2:0] S_ACK1 = 3'd2;
  localparam logic [2:0] S_CMD  = 3'd3;
  localparam logic [2:0] S_ACK2 = 3'd4;
  localparam logic [2:0] S_DONE = 3'd5;
  localparam logic [2:0] S_IGN  = 3'd6;
  localparam logic [7:0] WR_BYTE = {DEV_ADDR, 1'b0};

  logic [1:0]      scl_s, sda_s;
  logic [FILT-1:0] scl_h, sda_h;
  logic            scl_f, sda_f, scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_s <= '1;
      sda_s <= '1;
      scl_h <= '1;
      sda_h <= '1;
      scl_f <= 1'b1;
      sda_f <= 1'b1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_s <= {scl_s[0], scl_i};
      sda_s <= {sda_s[0], sda_i};
      scl_h <= {scl_h[FILT-2:0], scl_s[1]};
      sda_h <= {sda_h[FILT-2:0], sda_s[1]};
      if (&scl_h)       scl_f <= 1'b1;
      else if (~|scl_h) scl_f <= 1'b0;
      if (&sda_h)       sda_f <= 1'b1;
      else if (~|sda_h) sda_f <= 1'b0;
      scl_d <= scl_f;
      sda_d <= sda_f;
    end
  end

  wire scl_rise  = scl_f & ~scl_d;
  wire scl_fall  = ~scl_f & scl_d;
  wire start_det = scl_f & scl_d & sda_d & ~sda_f;
  wire stop_det  = scl_f & scl_d & ~sda_d & sda_f;

  logic [2:0] state, cnt, cmd, en;
  logic [6:0] shreg;
  logic       ack_on;
  wire  [7:0] byte_in = {shreg, sda_f};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cnt    <= '0;
      shreg  <= '0;
      cmd    <= '0;
      ack_on <= 1'b0;
      en     <= RESET_EN;
    end else if (start_det) begin
      state  <= S_ADDR;
      cnt    <= '0;
      ack_on <= 1'b0;
    end else if (stop_det) begin
      if (state == S_DONE) en <= cmd;
      state  <= S_IDLE;
      ack_on <= 1'b0;
    end else begin
      case (state)
        S_ADDR, S_CMD: if (scl_rise) begin
          shreg <= byte_in[6:0];
          cnt   <= cnt + 3'd1;
          if (cnt == 3'd7) begin
            if (state == S_CMD) begin
              cmd   <= byte_in[7:5];
              state <= S_ACK2;
            end else begin
              state <= (byte_in == WR_BYTE) ? S_ACK1 : S_IGN;
            end
          end
        end
        S_ACK1, S_ACK2: if (scl_fall) begin
          if (!ack_on) begin
            ack_on <= 1'b1;
          end else begin
            ack_on <= 1'b0;
            cnt    <= '0;
            state  <= (state == S_ACK1) ? S_CMD : S_DONE;
          end
        end
        S_DONE: if (scl_fall) state <= S_IGN;
        default: ;
      endcase
    end
  end

  assign sda_pull_o = ack_on;
  assign en_buck3_o = en[2];
  assign en_buck5_o = en[1];
  assign en_fly_o   = en[0];

endmodule

// File: rtl/smbus_enable_rx_chk.sv
module smbus_enable_rx_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_fall,
  input logic       start_det,
  input logic       stop_det,
  input logic [2:0] state,
  input logic       sda_pull,
  input logic [2:0] en
);
  localparam logic [2:0] S_ADDR = 3'd1;
  localparam logic [2:0] S_ACK1 = 3'd2;
  localparam logic [2:0] S_ACK2 = 3'd4;
  localparam logic [2:0] S_DONE = 3'd5;
  localparam logic [2:0] S_IGN  = 3'd6;

  // R5
  en_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en) |-> ($past(stop_det) && $past(state) == S_DONE));

  // R6
  early_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_det && state != S_DONE) |=> $stable(en));

  // R2
  pull_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_pull |-> (state == S_ACK1 || state == S_ACK2));

  // R4
  pull_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> $past(scl_fall));

  // R7
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (state == S_ADDR && !sda_pull));

  // R3
  ign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    state == S_IGN |-> !sda_pull);
endmodule

bind smbus_enable_rx smbus_enable_rx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_fall(scl_fall), .start_det(start_det),
  .stop_det(stop_det), .state(state), .sda_pull(ack_on), .en(en)
);

// File: tb/test_smbus_enable_rx.sv
module test_smbus_enable_rx;
  localparam int CLK_PERIOD = 10;
  localparam int Q = 20;
  localparam int GUARD = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_scl = 1'b1;
  logic bus_sda = 1'b1;
  logic pull, e3, e5, ef;
  wire  sda_line = bus_sda & ~pull;

  smbus_enable_rx i_smbus_enable_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(bus_scl), .sda_i(sda_line),
    .sda_pull_o(pull), .en_buck3_o(e3), .en_buck5_o(e5), .en_fly_o(ef)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0;
  int errors = 0;
  int quiet = GUARD;
  logic [2:0] exp_en = 3'b000;
  logic exp_pull = 1'b0;
  bit running = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (running) begin
        if (quiet > 0) quiet--;
        else begin
          check({e3, e5, ef} == exp_en, "R5 enables per clock", {e3, e5, ef}, exp_en);
          check(pull == exp_pull, "R2 pull per clock", pull, exp_pull);
        end
      end
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask
  task automatic set_scl(input logic v);
    bus_scl = v; quiet = GUARD;
  endtask
  task automatic set_sda(input logic v);
    bus_sda = v; quiet = GUARD;
  endtask

  task automatic do_start();
    set_sda(1); wq(Q); set_scl(1); wq(Q); set_sda(0); wq(Q); set_scl(0); wq(Q);
  endtask

  task automatic do_stop(input bit commit, input logic [7:0] c);
    set_sda(0); wq(Q); set_scl(1); wq(Q); set_sda(1);
    if (commit) exp_en = c[7:5];
    wq(Q);
  endtask

  task automatic send_bit(input logic b);
    set_sda(b); wq(Q); set_scl(1); wq(2*Q); set_scl(0); wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] v, input bit ack_exp, input string tag);
    for (int i = 7; i > 0; i--) send_bit(v[i]);
    set_sda(v[0]); wq(Q); set_scl(1); wq(2*Q); set_scl(0); exp_pull = ack_exp; wq(Q);
    set_sda(1); wq(Q); set_scl(1); wq(Q);
    check(pull == ack_exp, tag, pull, ack_exp);
    wq(Q); set_scl(0); exp_pull = 1'b0; wq(Q);
  endtask

  task automatic write_cmd(input logic [7:0] c);
    do_start();
    send_byte(8'h60, 1, "R2 address ack");
    send_byte(c, 1, "R4 command ack");
    do_stop(1, c);
    wq(2*GUARD);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    wq(3);
    check({e3, e5, ef} == 3'b000, "R10 enables in reset", {e3, e5, ef}, 0);
    check(pull == 1'b0, "R10 pull in reset", pull, 0);
    wq(2); rst_n = 1'b1; wq(1);
    check({e3, e5, ef} == 3'b000, "R10 enables after reset", {e3, e5, ef}, 0);
    check(pull == 1'b0, "R10 pull after reset", pull, 0);
    running = 1'b1;
    wq(GUARD + 2);

    // R1 R5: full write, 3.3 V buck and flyback on
    write_cmd(8'hA0);
    check({e3, e5, ef} == 3'b101, "R5 cmd A0", {e3, e5, ef}, 3'b101);

    // R5: low bits are ignored
    write_cmd(8'h5F);
    check({e3, e5, ef} == 3'b010, "R5 cmd 5F low bits ignored", {e3, e5, ef}, 3'b010);

    // R8: same state again
    write_cmd(8'h40);
    check({e3, e5, ef} == 3'b010, "R8 same state", {e3, e5, ef}, 3'b010);

    // R3: wrong address, then read bit
    do_start();
    send_byte(8'h62, 0, "R3 wrong address nack");
    send_byte(8'hE0, 0, "R3 ignored byte nack");
    do_stop(0, 8'h00); wq(2*GUARD);
    check({e3, e5, ef} == 3'b010, "R3 wrong address unchanged", {e3, e5, ef}, 3'b010);
    do_start();
    send_byte(8'h61, 0, "R3 read bit nack");
    do_stop(0, 8'h00); wq(2*GUARD);
    check({e3, e5, ef} == 3'b010, "R3 read unchanged", {e3, e5, ef}, 3'b010);

    // R6: stop right after address ack, and stop inside command byte
    do_start();
    send_byte(8'h60, 1, "R2 address ack before early stop");
    do_stop(0, 8'h00); wq(2*GUARD);
    check({e3, e5, ef} == 3'b010, "R6 stop after address", {e3, e5, ef}, 3'b010);
    do_start();
    send_byte(8'h60, 1, "R2 address ack");
    send_bit(1); send_bit(1); send_bit(1); send_bit(0);
    do_stop(0, 8'h00); wq(2*GUARD);
    check({e3, e5, ef} == 3'b010, "R6 stop inside command", {e3, e5, ef}, 3'b010);

    // R7: repeated start inside command byte
    do_start();
    send_byte(8'h60, 1, "R2 address ack");
    send_bit(0); send_bit(0); send_bit(1);
    do_start();
    send_byte(8'h60, 1, "R7 address ack after restart");
    send_byte(8'hE0, 1, "R7 command ack after restart");
    do_stop(1, 8'hE0); wq(2*GUARD);
    check({e3, e5, ef} == 3'b111, "R7 restart commit", {e3, e5, ef}, 3'b111);

    // R11: second data byte invalidates
    do_start();
    send_byte(8'h60, 1, "R2 address ack");
    send_byte(8'h00, 1, "R4 command ack");
    send_byte(8'h00, 0, "R11 extra byte nack");
    do_stop(0, 8'h00); wq(2*GUARD);
    check({e3, e5, ef} == 3'b111, "R11 extra byte unchanged", {e3, e5, ef}, 3'b111);

    // R9: one-cycle SCL pulse inside address byte is filtered
    do_start();
    send_bit(0); send_bit(1);
    set_scl(1); wq(1); set_scl(0); wq(Q);
    send_bit(1); send_bit(0); send_bit(0); send_bit(0); send_bit(0);
    set_sda(0); wq(Q); set_scl(1); wq(2*Q); set_scl(0); exp_pull = 1'b1; wq(Q);
    set_sda(1); wq(Q); set_scl(1); wq(Q);
    check(pull == 1'b1, "R9 ack despite glitch", pull, 1);
    wq(Q); set_scl(0); exp_pull = 1'b0; wq(Q);
    send_byte(8'h00, 1, "R4 command ack");
    do_stop(1, 8'h00); wq(2*GUARD);
    check({e3, e5, ef} == 3'b000, "R5 cmd 00 shuts all", {e3, e5, ef}, 3'b000);

    // R1: one-cycle SDA dip with SCL high is not a start
    set_sda(0); wq(1); set_sda(1); wq(2*GUARD);
    send_bit(1); send_bit(1); wq(2*GUARD);
    check(pull == 1'b0, "R1 glitch not a start", pull, 0);

    running = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule